// File: doc/BRIEF.md
# Chroma downsampler

This block takes a stream of 10-bit YCbCr 4:4:4 pixels and thins out the chroma. Chroma can be halved horizontally, vertically or both ways. Each axis has its own method: dropping samples, averaging a pair, or one of two filters with taps held in registers. Luma is never resampled. Every accepted input pixel yields exactly one output pixel through a single register stage. A flag on each output pixel tells whether that pixel carries a chroma sample.

The pixel interface is a valid/ready stream. A start-of-frame marker sits on the first pixel and an end-of-line marker sits on the last pixel of each line. Vertical reduction keeps one line of horizontally reduced chroma in an internal buffer. It merges that line with the following line. Configuration arrives through a simple write port. A frame-size register drives an end-of-frame marker on the output. An output option rounds every component down to 8 bits.

Top module: `chroma_dsamp`

## Requirements
- R1: After reset, out_valid is 0, in_ready is 1, and the mode register is 0. The clamp range defaults to 0..1023, so pixels pass through unchanged with out_cvalid 1.
- R2: When mode bit 0 (global enable) is clear, every output pixel equals its input pixel and has out_cvalid 1, whatever the other mode bits hold.
- R3: Each accepted input gives one output on the next cycle. in_ready is !out_valid || out_ready. An output that is not taken holds all its fields.
- R4: The mode register is at address 0. Bit 0 is the global enable, bit 1 is the horizontal enable and bit 2 is the vertical enable. Bits 4:3 pick the horizontal method and bits 6:5 pick the vertical method. The method codes are 0 drop, 1 average, 2 co-sited filter and 3 off-sited filter. Bit 7 selects 8-bit output. An axis is active only when the global enable and its own enable are both set.
- R5: With horizontal reduction active, only odd columns carry chroma (out_cvalid 1). Even columns output chroma 0 with out_cvalid 0. Drop yields the even-column sample of each pair.
- R6: Average yields (a+b+1)>>1 for the even and odd sample of a pair.
- R7: The horizontal filter sums three terms: tap [9:0] times the previous odd-column sample (the column-0 sample at the start of a line), tap [19:10] times the even sample and tap [29:20] times the odd sample. Taps are signed. The co-sited taps are at address 3 and the off-sited taps at address 4, with defaults (64,128,64) and (0,128,128). The result is (sum+128)>>>8, clamped to the range in address 2 (minimum in bits 15:0, maximum in bits 31:16).
- R8: With vertical reduction active, lines are counted from start-of-frame. Even lines carry no chroma. Each odd line combines, per chroma column, the buffered even-line sample (a) with its own sample (b). Drop yields a and average yields (a+b+1)>>1. The filters use tap [9:0] on a and tap [19:10] on b, taken from address 5 (co-sited, default 256,0) or address 6 (off-sited, default 128,128), with the same rounding and clamp as R7.
- R9: With both axes active, horizontal reduction is applied first and its result feeds the vertical stage.
- R10: With the global enable and bit 7 set, each output component (luma and chroma) is min(255,(v+2)>>2).
- R11: Address 1 holds the frame width in bits 15:0 and the height in bits 31:16. out_eof is 1 on the pixel at column width-1 of line height-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Input pixel accepted when high with in_valid |
| in_sof | input | 1 | First pixel of a frame |
| in_eol | input | 1 | Last pixel of a line |
| in_y | input | 10 | Input luma |
| in_cb | input | 10 | Input blue-difference chroma |
| in_cr | input | 10 | Input red-difference chroma |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Downstream accepts output |
| out_sof | output | 1 | Frame start marker, delayed |
| out_eol | output | 1 | Line end marker, delayed |
| out_eof | output | 1 | Last pixel of the frame per size register |
| out_cvalid | output | 1 | Pixel carries a chroma sample |
| out_y | output | 10 | Output luma |
| out_cb | output | 10 | Output blue-difference chroma |
| out_cr | output | 10 | Output red-difference chroma |

## Verification
The assertions assume that configuration registers change only while no pixel is in flight. They also assume that lines fit in the line buffer, that start-of-frame marks column 0 of line 0, and that lines have an even length when horizontal reduction is on. The stimulus keeps to these assumptions. It writes registers only with in_valid low and the output stage drained. Every frame starts with in_sof. Lines have two or four pixels. Stalls are applied only by holding out_ready low while a single pixel sits in the output stage.

// File: rtl/chroma_dsamp_pkg.sv
// Shared types for the chroma downsampler.
// The mode struct is laid out so that a cast of the 8-bit mode word fills it.
package chroma_dsamp_pkg;

    typedef enum logic [1:0] {
        M_DROP    = 2'd0,
        M_AVG     = 2'd1,
        M_COSITE  = 2'd2,
        M_OFFSITE = 2'd3
    } method_e;

    typedef struct packed {
        logic    depth8;   // bit 7
        method_e vmeth;    // bits 6:5
        method_e hmeth;    // bits 4:3
        logic    ven;      // bit 2
        logic    hen;      // bit 1
        logic    en;       // bit 0
    } mode_t;

    localparam int A_MODE  = 0;
    localparam int A_SIZE  = 1;
    localparam int A_CLAMP = 2;
    localparam int A_HCO   = 3;
    localparam int A_HOFF  = 4;
    localparam int A_VCO   = 5;
    localparam int A_VOFF  = 6;
    localparam int FIELD   = 10;   // spacing of tap fields in a tap word

endpackage

// File: rtl/chroma_dsamp_regs.sv
// Configuration registers of the chroma downsampler.
// Assumes TAP_W <= 10 and PIX_W <= 16; writes take effect the next cycle.
module chroma_dsamp_regs
    import chroma_dsamp_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int PIX_W  = 10,
    parameter int TAP_W  = 10
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [31:0]           wdata,
    output mode_t                 mode,
    output logic [15:0]           dim_w,
    output logic [15:0]           dim_h,
    output logic [PIX_W-1:0]      clamp_lo,
    output logic [PIX_W-1:0]      clamp_hi,
    output logic [3*TAP_W-1:0]    hco,
    output logic [3*TAP_W-1:0]    hoff,
    output logic [2*TAP_W-1:0]    vco,
    output logic [2*TAP_W-1:0]    voff
);

    localparam logic [3*TAP_W-1:0] HCO_DEF  = {TAP_W'(64), TAP_W'(128), TAP_W'(64)};
    localparam logic [3*TAP_W-1:0] HOFF_DEF = {TAP_W'(128), TAP_W'(128), TAP_W'(0)};
    localparam logic [2*TAP_W-1:0] VCO_DEF  = {TAP_W'(0), TAP_W'(256)};
    localparam logic [2*TAP_W-1:0] VOFF_DEF = {TAP_W'(128), TAP_W'(128)};

    // Register file update on write strobe, defaults on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode     <= '0;
            dim_w    <= '0;
            dim_h    <= '0;
            clamp_lo <= '0;
            clamp_hi <= '1;
            hco      <= HCO_DEF;
            hoff     <= HOFF_DEF;
            vco      <= VCO_DEF;
            voff     <= VOFF_DEF;
        end else if (wr) begin
            case (int'(addr))
                A_MODE:  mode <= mode_t'(wdata[7:0]);
                A_SIZE:  begin dim_w <= wdata[15:0]; dim_h <= wdata[31:16]; end
                A_CLAMP: begin clamp_lo <= wdata[0 +: PIX_W]; clamp_hi <= wdata[16 +: PIX_W]; end
                A_HCO:   hco  <= {wdata[2*FIELD +: TAP_W], wdata[FIELD +: TAP_W], wdata[0 +: TAP_W]};
                A_HOFF:  hoff <= {wdata[2*FIELD +: TAP_W], wdata[FIELD +: TAP_W], wdata[0 +: TAP_W]};
                A_VCO:   vco  <= {wdata[FIELD +: TAP_W], wdata[0 +: TAP_W]};
                A_VOFF:  voff <= {wdata[FIELD +: TAP_W], wdata[0 +: TAP_W]};
                default: ;
            endcase
        end
    end

    // R4
    mode_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && int'(addr) == A_MODE) |=> (mode == mode_t'($past(wdata[7:0]))));

endmodule

// File: rtl/chroma_dsamp_reduce.sv
// Combinational reducer: merges two samples (a, b) with a left neighbour p
// by drop, average, or a signed 3-tap filter with rounding and clamping.
// Assumes the taps keep the sum inside ACC_W bits.
module chroma_dsamp_reduce
    import chroma_dsamp_pkg::*;
#(
    parameter int PIX_W = 10,
    parameter int TAP_W = 10,
    parameter int FRAC  = 8
) (
    input  method_e                  meth,
    input  logic [PIX_W-1:0]         p,
    input  logic [PIX_W-1:0]         a,
    input  logic [PIX_W-1:0]         b,
    input  logic signed [TAP_W-1:0]  t0,
    input  logic signed [TAP_W-1:0]  t1,
    input  logic signed [TAP_W-1:0]  t2,
    input  logic [PIX_W-1:0]         lo,
    input  logic [PIX_W-1:0]         hi,
    output logic [PIX_W-1:0]         r
);

    localparam int ACC_W = PIX_W + TAP_W + 3;
    localparam int RND   = 1 << (FRAC - 1);

    logic signed [ACC_W-1:0] acc, scaled, slo, shi;
    logic        [PIX_W:0]   pair;

    // Filter sum, rounding and clamp bounds.
    always_comb begin
        acc = $signed({{(ACC_W-PIX_W){1'b0}}, p}) * $signed({{(ACC_W-TAP_W){t0[TAP_W-1]}}, t0})
            + $signed({{(ACC_W-PIX_W){1'b0}}, a}) * $signed({{(ACC_W-TAP_W){t1[TAP_W-1]}}, t1})
            + $signed({{(ACC_W-PIX_W){1'b0}}, b}) * $signed({{(ACC_W-TAP_W){t2[TAP_W-1]}}, t2})
            + $signed(ACC_W'(RND));
        scaled = acc >>> FRAC;
        slo    = $signed({{(ACC_W-PIX_W){1'b0}}, lo});
        shi    = $signed({{(ACC_W-PIX_W){1'b0}}, hi});
        pair   = {1'b0, a} + {1'b0, b} + (PIX_W+1)'(1);
    end

    // Method select.
    always_comb begin
        case (meth)
            M_DROP:  r = a;
            M_AVG:   r = pair[PIX_W:1];
            default: begin
                if (scaled < slo)      r = lo;
                else if (scaled > shi) r = hi;
                else                   r = scaled[PIX_W-1:0];
            end
        endcase
    end

endmodule

// File: rtl/chroma_dsamp_linebuf.sv
// Single-line chroma store: synchronous write, combinational read.
// Holds no reset; contents are only read after being written in the same frame.
module chroma_dsamp_linebuf #(
    parameter int DEPTH = 64,
    parameter int DW    = 20,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [DW-1:0] wr_data,
    input  logic [IW-1:0] rd_idx,
    output logic [DW-1:0] rd_data
);

    logic [DW-1:0] mem [DEPTH];

    // Store one even-line chroma pair per column.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_idx] <= wr_data;
    end

    assign rd_data = mem[rd_idx];

endmodule

// File: rtl/chroma_dsamp.sv
// Streaming chroma downsampler, one register stage from input to output.
// Assumes: registers change only with no pixel in flight; in_sof marks
// column 0 of line 0; lines fit LINE_MAX; even line length when H is on.
module chroma_dsamp
    import chroma_dsamp_pkg::*;
#(
    parameter int PIX_W    = 10,
    parameter int TAP_W    = 10,
    parameter int FRAC     = 8,
    parameter int LINE_MAX = 64,
    parameter int ADDR_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              in_sof,
    input  logic              in_eol,
    input  logic [PIX_W-1:0]  in_y,
    input  logic [PIX_W-1:0]  in_cb,
    input  logic [PIX_W-1:0]  in_cr,
    output logic              out_valid,
    input  logic              out_ready,
    output logic              out_sof,
    output logic              out_eol,
    output logic              out_eof,
    output logic              out_cvalid,
    output logic [PIX_W-1:0]  out_y,
    output logic [PIX_W-1:0]  out_cb,
    output logic [PIX_W-1:0]  out_cr
);

    localparam int BI_W = $clog2(LINE_MAX);
    localparam int NCH  = 2;

    mode_t                mode;
    logic [15:0]          dim_w, dim_h;
    logic [PIX_W-1:0]     clamp_lo, clamp_hi;
    logic [3*TAP_W-1:0]   hco, hoff, htaps;
    logic [2*TAP_W-1:0]   vco, voff, vtaps;

    chroma_dsamp_regs #(.ADDR_W(ADDR_W), .PIX_W(PIX_W), .TAP_W(TAP_W)) i_regs (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
        .mode(mode), .dim_w(dim_w), .dim_h(dim_h),
        .clamp_lo(clamp_lo), .clamp_hi(clamp_hi),
        .hco(hco), .hoff(hoff), .vco(vco), .voff(voff)
    );

    logic        fire, h_on, v_on, d8, h_ok, c_ok, wr_line;
    logic [15:0] col_q, line_q, col, line;
    logic [BI_W-1:0] bidx;
    logic [NCH*PIX_W-1:0] buf_wr, buf_rd;
    logic [PIX_W-1:0] cur   [NCH];
    logic [PIX_W-1:0] prev_q[NCH];
    logic [PIX_W-1:0] even_q[NCH];
    logic [PIX_W-1:0] left  [NCH];
    logic [PIX_W-1:0] hres  [NCH];
    logic [PIX_W-1:0] hsamp [NCH];
    logic [PIX_W-1:0] vres  [NCH];
    logic [PIX_W-1:0] csamp [NCH];

    assign in_ready = !out_valid || out_ready;
    assign fire     = in_valid && in_ready;
    assign h_on     = mode.en && mode.hen;
    assign v_on     = mode.en && mode.ven;
    assign d8       = mode.en && mode.depth8;
    assign col      = in_sof ? 16'd0 : col_q;
    assign line     = in_sof ? 16'd0 : line_q;
    assign h_ok     = !h_on || col[0];
    assign c_ok     = h_ok && (!v_on || line[0]);
    assign bidx     = h_on ? col[BI_W:1] : col[BI_W-1:0];
    assign htaps    = (mode.hmeth == M_OFFSITE) ? hoff : hco;
    assign vtaps    = (mode.vmeth == M_OFFSITE) ? voff : vco;
    assign wr_line  = fire && v_on && h_ok && !line[0];
    assign cur[0]   = in_cb;
    assign cur[1]   = in_cr;

    // Rounds a component to 8 bits with saturation when requested.
    function automatic logic [PIX_W-1:0] fmt_out(input logic [PIX_W-1:0] v, input logic sel8);
        logic [PIX_W:0] s;
        s = {1'b0, v} + (PIX_W+1)'(2);
        if (!sel8)        return v;
        if (s[PIX_W])     return {2'b00, {(PIX_W-2){1'b1}}};
        return {2'b00, s[PIX_W-1:2]};
    endfunction

    // Column and line position counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col_q  <= '0;
            line_q <= '0;
        end else if (fire) begin
            col_q  <= in_eol ? 16'd0 : col + 16'd1;
            line_q <= in_eol ? line + 16'd1 : line;
        end
    end

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        // Horizontal neighbour history: even sample of the pair, last odd sample.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                prev_q[ch] <= '0;
                even_q[ch] <= '0;
            end else if (fire) begin
                if (col[0]) prev_q[ch] <= cur[ch];
                else        even_q[ch] <= cur[ch];
            end
        end

        assign left[ch] = (col == 16'd1) ? even_q[ch] : prev_q[ch];

        chroma_dsamp_reduce #(.PIX_W(PIX_W), .TAP_W(TAP_W), .FRAC(FRAC)) i_hred (
            .meth(mode.hmeth), .p(left[ch]), .a(even_q[ch]), .b(cur[ch]),
            .t0($signed(htaps[0 +: TAP_W])), .t1($signed(htaps[TAP_W +: TAP_W])),
            .t2($signed(htaps[2*TAP_W +: TAP_W])),
            .lo(clamp_lo), .hi(clamp_hi), .r(hres[ch])
        );

        assign hsamp[ch] = h_on ? hres[ch] : cur[ch];
        assign buf_wr[ch*PIX_W +: PIX_W] = hsamp[ch];

        chroma_dsamp_reduce #(.PIX_W(PIX_W), .TAP_W(TAP_W), .FRAC(FRAC)) i_vred (
            .meth(mode.vmeth), .p('0), .a(buf_rd[ch*PIX_W +: PIX_W]), .b(hsamp[ch]),
            .t0('0), .t1($signed(vtaps[0 +: TAP_W])), .t2($signed(vtaps[TAP_W +: TAP_W])),
            .lo(clamp_lo), .hi(clamp_hi), .r(vres[ch])
        );

        assign csamp[ch] = v_on ? vres[ch] : hsamp[ch];
    end

    chroma_dsamp_linebuf #(.DEPTH(LINE_MAX), .DW(NCH*PIX_W)) i_linebuf (
        .clk(clk), .wr_en(wr_line), .wr_idx(bidx), .wr_data(buf_wr),
        .rd_idx(bidx), .rd_data(buf_rd)
    );

    // Output register with valid/ready hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_sof    <= 1'b0;
            out_eol    <= 1'b0;
            out_eof    <= 1'b0;
            out_cvalid <= 1'b0;
            out_y      <= '0;
            out_cb     <= '0;
            out_cr     <= '0;
        end else if (fire) begin
            out_valid  <= 1'b1;
            out_sof    <= in_sof;
            out_eol    <= in_eol;
            out_eof    <= (col == dim_w - 16'd1) && (line == dim_h - 16'd1);
            out_cvalid <= c_ok;
            out_y      <= fmt_out(in_y, d8);
            out_cb     <= c_ok ? fmt_out(csamp[0], d8) : '0;
            out_cr     <= c_ok ? fmt_out(csamp[1], d8) : '0;
        end else if (out_ready) begin
            out_valid  <= 1'b0;
        end
    end

    // R3
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable({out_y, out_cb, out_cr, out_cvalid, out_sof, out_eol, out_eof})));

    // R2
    passthru_cvalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !mode.en) |-> out_cvalid);

    // R10
    depth8_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && d8) |-> (out_y[PIX_W-1 -: 2] == 2'b00 && out_cb[PIX_W-1 -: 2] == 2'b00 && out_cr[PIX_W-1 -: 2] == 2'b00));

    // R5
    even_col_nochroma_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && h_on && !col[0]) |=> !out_cvalid);

    // R8
    even_line_nochroma_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && v_on && !line[0]) |=> !out_cvalid);

    // R7
    clamp_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_cvalid && h_on && !v_on && !d8 && mode.hmeth[1])
        |-> (out_cb >= clamp_lo && out_cb <= clamp_hi && out_cr >= clamp_lo && out_cr <= clamp_hi));

    // R8
    line_fit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> (col < 16'(LINE_MAX)));

endmodule

// File: tb/test_chroma_dsamp.sv
module test_chroma_dsamp;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_wr = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic in_valid = 1'b0, in_sof = 1'b0, in_eol = 1'b0, out_ready = 1'b1;
    logic [9:0] in_y = '0, in_cb = '0, in_cr = '0;
    logic in_ready, out_valid, out_sof, out_eol, out_eof, out_cvalid;
    logic [9:0] out_y, out_cb, out_cr;

    int total = 0;
    int bad = 0;
    int cap_n = 0;
    logic [9:0] cap_y[16], cap_cb[16], cap_cr[16];
    logic       cap_cv[16], cap_eof[16];

    always #2 clk = ~clk;

    chroma_dsamp i_chroma_dsamp (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .in_valid(in_valid), .in_ready(in_ready), .in_sof(in_sof), .in_eol(in_eol),
        .in_y(in_y), .in_cb(in_cb), .in_cr(in_cr),
        .out_valid(out_valid), .out_ready(out_ready), .out_sof(out_sof), .out_eol(out_eol),
        .out_eof(out_eof), .out_cvalid(out_cvalid),
        .out_y(out_y), .out_cb(out_cb), .out_cr(out_cr)
    );

    // Records every output beat that will be taken at the next edge.
    always @(negedge clk) begin
        if (out_valid && out_ready && cap_n < 16) begin
            cap_y[cap_n]   <= out_y;
            cap_cb[cap_n]  <= out_cb;
            cap_cr[cap_n]  <= out_cr;
            cap_cv[cap_n]  <= out_cvalid;
            cap_eof[cap_n] <= out_eof;
            cap_n <= cap_n + 1;
        end
    end

    // {mode, cb_a, cb_b, exp_cb, exp_cr}; cr inputs are 1023-cb.
    localparam logic [47:0] VEC [8] = '{
        {8'h03, 10'd100,  10'd200, 10'd100, 10'd923},  // R5 drop
        {8'h0B, 10'd100,  10'd200, 10'd150, 10'd873},  // R6 average
        {8'h0B, 10'd1,    10'd2,   10'd2,   10'd1022}, // R6 rounding
        {8'h13, 10'd100,  10'd200, 10'd125, 10'd898},  // R7 co-sited
        {8'h1B, 10'd100,  10'd200, 10'd150, 10'd873},  // R7 off-sited
        {8'h83, 10'd1023, 10'd0,   10'd255, 10'd0},    // R10 saturation
        {8'h8B, 10'd6,    10'd7,   10'd2,   10'd254},  // R10 rounding
        {8'h06, 10'd100,  10'd200, 10'd200, 10'd823}   // R2 enable clear
    };

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic wreg(input int a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 3'(a); reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic send(input int y, input int cb, input int cr, input logic sof, input logic eol);
        @(negedge clk);
        in_valid = 1'b1; in_y = 10'(y); in_cb = 10'(cb); in_cr = 10'(cr); in_sof = sof; in_eol = eol;
        @(negedge clk);
        in_valid = 1'b0; in_sof = 1'b0; in_eol = 1'b0;
    endtask

    task automatic settle();
        repeat (2) @(negedge clk);
    endtask

    function automatic int to8(input int v);
        int r;
        r = (v + 2) >> 2;
        return (r > 255) ? 255 : r;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog act=0 exp=1");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 out_valid", int'(out_valid), 0);
        check("R1 in_ready", int'(in_ready), 1);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 in_ready after reset", int'(in_ready), 1);
        cap_n = 0;
        send(7, 321, 654, 1'b1, 1'b1);
        settle();
        check("R1 default cvalid", int'(cap_cv[0]), 1);
        check("R1 default cb", int'(cap_cb[0]), 321);
        check("R1 default cr", int'(cap_cr[0]), 654);

        // Table walk: single two-pixel lines.
        for (int i = 0; i < 8; i++) begin
            logic [7:0] md;
            int a, b, ecb, ecr;
            md = VEC[i][47:40]; a = int'(VEC[i][39:30]); b = int'(VEC[i][29:20]);
            ecb = int'(VEC[i][19:10]); ecr = int'(VEC[i][9:0]);
            wreg(0, {24'd0, md});
            cap_n = 0;
            send(a, a, 1023 - a, 1'b1, 1'b0);
            send(b, b, 1023 - b, 1'b0, 1'b1);
            settle();
            check("R4/R5 first-pixel cvalid", int'(cap_cv[0]), (md[0] && md[1]) ? 0 : 1);
            check("R4 pair cvalid", int'(cap_cv[1]), 1);
            check("R5/R6/R7/R10 cb", int'(cap_cb[1]), ecb);
            check("R5/R6/R7/R10 cr", int'(cap_cr[1]), ecr);
            check("R10 luma", int'(cap_y[1]), (md[0] && md[7]) ? to8(b) : b);
        end

        // R7: left tap uses previous odd sample, replicated at column 0.
        wreg(0, 32'h13);
        wreg(3, 32'h0000_0100);
        cap_n = 0;
        send(0, 10, 10, 1'b1, 1'b0);
        send(0, 20, 20, 1'b0, 1'b0);
        send(0, 30, 30, 1'b0, 1'b0);
        send(0, 40, 40, 1'b0, 1'b1);
        settle();
        check("R7 left tap col1", int'(cap_cb[1]), 10);
        check("R7 left tap col3", int'(cap_cb[3]), 20);

        // R7: negative result clamps to minimum.
        wreg(3, 32'h3000_0000);
        cap_n = 0;
        send(0, 100, 923, 1'b1, 1'b0);
        send(0, 200, 823, 1'b0, 1'b1);
        settle();
        check("R7 negative clamp cb", int'(cap_cb[1]), 0);
        check("R7 negative clamp cr", int'(cap_cr[1]), 0);

        // R7: programmed clamp range.
        wreg(3, 32'h0402_0040);
        wreg(2, 32'h0200_0100);
        cap_n = 0;
        send(0, 100, 923, 1'b1, 1'b0);
        send(0, 200, 823, 1'b0, 1'b1);
        settle();
        check("R7 clamp min", int'(cap_cb[1]), 256);
        check("R7 clamp max", int'(cap_cr[1]), 512);
        wreg(2, 32'h03FF_0000);

        // R8: vertical drop and off-sited filter over two lines.
        for (int m = 0; m < 2; m++) begin
            wreg(0, (m == 0) ? 32'h05 : 32'h65);
            cap_n = 0;
            send(0, 100, 100, 1'b1, 1'b0);
            send(0, 300, 300, 1'b0, 1'b1);
            send(0, 200, 200, 1'b0, 1'b0);
            send(0, 400, 400, 1'b0, 1'b1);
            settle();
            check("R8 even line no chroma", int'(cap_cv[0]), 0);
            check("R8 odd line chroma", int'(cap_cv[2]), 1);
            check("R8 col0", int'(cap_cb[2]), (m == 0) ? 100 : 150);
            check("R8 col1", int'(cap_cr[3]), (m == 0) ? 300 : 350);
        end

        // R9 and R11: both axes averaging, frame 2x2.
        wreg(0, 32'h2F);
        wreg(1, 32'h0002_0002);
        cap_n = 0;
        send(0, 100, 100, 1'b1, 1'b0);
        send(0, 200, 200, 1'b0, 1'b1);
        send(0, 300, 300, 1'b0, 1'b0);
        send(0, 500, 500, 1'b0, 1'b1);
        settle();
        check("R9 line0 pair no chroma", int'(cap_cv[1]), 0);
        check("R9 line1 even col no chroma", int'(cap_cv[2]), 0);
        check("R9 combined", int'(cap_cb[3]), 275);
        check("R11 eof not early", int'(cap_eof[1]), 0);
        check("R11 eof last pixel", int'(cap_eof[3]), 1);

        // R3: stall holds the output and blocks input.
        wreg(0, 32'h0);
        out_ready = 1'b0;
        send(5, 6, 7, 1'b1, 1'b1);
        check("R3 valid under stall", int'(out_valid), 1);
        check("R3 ready low under stall", int'(in_ready), 0);
        repeat (3) @(negedge clk);
        check("R3 held luma", int'(out_y), 5);
        check("R3 held cb", int'(out_cb), 6);
        out_ready = 1'b1;
        @(negedge clk);
        check("R3 drained", int'(out_valid), 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule